// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block turns a set of programmable raster parameters into the three video framing strobes: horizontal sync, vertical sync and data-enable. A free-running pixel counter walks each line and a line counter walks each frame. Both limits come from active-plus-blank totals. Sync pulses are placed by an offset measured from the end of the active region, and they last a programmed width. Each strobe has its own polarity. A control-period flag marks the blanking pixels that still have enough of the line left to hold a minimum-length control period.

Software loads the parameters one byte at a time over a simple write port into a staging copy. The whole staging copy moves into the working copy only when the counters wrap back to the first pixel of a frame. Because of that, a frame never runs on a mix of old and new settings. Two mode bits, DVI operation and interlaced operation, are stored and presented on outputs. They do not change the raster.

Top module: `vid_timing_gen`

## Requirements
- R1: The pixel counter runs from 0 to htot-1, where htot = horizontal active + horizontal blank, and then returns to 0. The line counter advances by one whenever the pixel counter wraps. It runs from 0 to vtot-1, where vtot = vertical active + vertical blank, and then returns to 0. Reset leaves both counters at 0.
- R2: The register map is as follows. A write with reg_we high stores reg_wdata into the byte that reg_addr selects. The addresses are: 0 config; 1/2 horizontal active low/high; 3/4 horizontal blank low/high; 5/6 vertical active low/high; 7 vertical blank; 8/9 horizontal sync delay low/high; 10/11 horizontal sync width low/high; 12 vertical sync delay; 13 vertical sync width; 14 minimum control duration. A write to address 15 has no effect on any output.
- R3: The data-enable is at its active level exactly when pix_cnt < horizontal active and line_cnt < vertical active.
- R4: The horizontal sync is at its active level exactly when hact+hdelay <= pix_cnt < hact+hdelay+hwidth.
- R5: The vertical sync is at its active level exactly when vact+vdelay <= line_cnt < vact+vdelay+vwidth. This holds on every pixel of those lines.
- R6: Three config bits set the active level of each strobe: bit 6 for vsync, bit 5 for hsync and bit 4 for data-enable. A bit value of 1 makes that strobe active-high, and 0 makes it active-low.
- R7: ctrl_period is high exactly when the pixel is in blanking (data-enable not at its active level) and htot - pix_cnt >= the minimum control duration.
- R8: Config bit 3 appears on dvi_mode and config bit 0 appears on interlaced.
- R9: Register writes reach the outputs only from the first pixel of the next frame, that is, after the counters wrap from (htot-1, vtot-1) to (0, 0). A write in the same cycle as that wrap is held back until the frame after.
- R10: Reset loads these defaults: hact 16, hblank 8, vact 4, vblank 3, hdelay 2, hwidth 3, vdelay 1, vwidth 1, minimum control duration 12, config 0x70.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Byte write strobe |
| reg_addr | input | 4 | Byte register select |
| reg_wdata | input | 8 | Byte write data |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| de | output | 1 | Data-enable, polarity applied |
| ctrl_period | output | 1 | Blanking pixel with room for a control period |
| pix_cnt | output | 16 | Current pixel within the line |
| line_cnt | output | 16 | Current line within the frame |
| dvi_mode | output | 1 | Stored DVI mode bit |
| interlaced | output | 1 | Stored interlaced mode bit |

## Verification
Two events can fall in the same cycle: a register write landing and the frame wrap that copies the staging registers into the working set. The bench follows its own model of the counters. It waits until the model sits on the last pixel of the last line, and then places a write of a new horizontal active width on exactly that clock edge. The check at pixel 15 of the next frame's first line must still show the old width. The same check one frame later must show the new width. Every other cycle is compared against the model as well.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int HW  = 16;
  localparam int VW  = 16;
  localparam int VBW = 8;
  localparam int CW  = 8;
  localparam int AW  = 4;

  typedef struct packed {
    logic           vpol;
    logic           hpol;
    logic           depol;
    logic           dvi;
    logic           intl;
    logic [CW-1:0]  ctrl_min;
    logic [VBW-1:0] vsw;
    logic [VBW-1:0] vsd;
    logic [VBW-1:0] vblk;
    logic [VW-1:0]  vact;
    logic [HW-1:0]  hsw;
    logic [HW-1:0]  hsd;
    logic [HW-1:0]  hblk;
    logic [HW-1:0]  hact;
  } timing_t;

  localparam logic [AW-1:0] A_CFG    = 4'd0;
  localparam logic [AW-1:0] A_HACT_L = 4'd1;
  localparam logic [AW-1:0] A_HACT_H = 4'd2;
  localparam logic [AW-1:0] A_HBLK_L = 4'd3;
  localparam logic [AW-1:0] A_HBLK_H = 4'd4;
  localparam logic [AW-1:0] A_VACT_L = 4'd5;
  localparam logic [AW-1:0] A_VACT_H = 4'd6;
  localparam logic [AW-1:0] A_VBLK   = 4'd7;
  localparam logic [AW-1:0] A_HSD_L  = 4'd8;
  localparam logic [AW-1:0] A_HSD_H  = 4'd9;
  localparam logic [AW-1:0] A_HSW_L  = 4'd10;
  localparam logic [AW-1:0] A_HSW_H  = 4'd11;
  localparam logic [AW-1:0] A_VSD    = 4'd12;
  localparam logic [AW-1:0] A_VSW    = 4'd13;
  localparam logic [AW-1:0] A_CMIN   = 4'd14;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter timing_t RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          load,
  output timing_t       act
);
  timing_t stg, stg_nx, act_nx;

  always_comb begin
    stg_nx = stg;
    if (we) begin
      unique case (addr)
        A_CFG: begin
          stg_nx.vpol  = wdata[6];
          stg_nx.hpol  = wdata[5];
          stg_nx.depol = wdata[4];
          stg_nx.dvi   = wdata[3];
          stg_nx.intl  = wdata[0];
        end
        A_HACT_L: stg_nx.hact[7:0]   = wdata;
        A_HACT_H: stg_nx.hact[15:8]  = wdata;
        A_HBLK_L: stg_nx.hblk[7:0]   = wdata;
        A_HBLK_H: stg_nx.hblk[15:8]  = wdata;
        A_VACT_L: stg_nx.vact[7:0]   = wdata;
        A_VACT_H: stg_nx.vact[15:8]  = wdata;
        A_VBLK:   stg_nx.vblk        = wdata;
        A_HSD_L:  stg_nx.hsd[7:0]    = wdata;
        A_HSD_H:  stg_nx.hsd[15:8]   = wdata;
        A_HSW_L:  stg_nx.hsw[7:0]    = wdata;
        A_HSW_H:  stg_nx.hsw[15:8]   = wdata;
        A_VSD:    stg_nx.vsd         = wdata;
        A_VSW:    stg_nx.vsw         = wdata;
        A_CMIN:   stg_nx.ctrl_min    = wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    act_nx = act;
    if (load) act_nx = stg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= RST;
      act <= RST;
    end else begin
      stg <= stg_nx;
      act <= act_nx;
    end
  end
endmodule

// File: rtl/vtg_counters.sv
module vtg_counters
  import vtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW:0]   htot,
  input  logic [VW:0]   vtot,
  output logic [HW-1:0] pix,
  output logic [VW-1:0] line,
  output logic          frame_end
);
  logic [HW-1:0] pix_nx;
  logic [VW-1:0] line_nx;
  logic          pix_last, line_last;

  assign pix_last  = ({1'b0, pix} + 1'b1) >= htot;
  assign line_last = ({1'b0, line} + 1'b1) >= vtot;
  assign frame_end = pix_last && line_last;

  always_comb begin
    pix_nx  = pix + 1'b1;
    line_nx = line;
    if (pix_last) begin
      pix_nx  = '0;
      line_nx = line_last ? '0 : line + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix  <= '0;
      line <= '0;
    end else begin
      pix  <= pix_nx;
      line <= line_nx;
    end
  end
endmodule

// File: rtl/vtg_decode.sv
module vtg_decode
  import vtg_pkg::*;
(
  input  logic [HW-1:0]  pix,
  input  logic [VW-1:0]  line,
  input  logic [HW:0]    htot,
  input  logic [HW-1:0]  hact,
  input  logic [HW-1:0]  hsd,
  input  logic [HW-1:0]  hsw,
  input  logic [VW-1:0]  vact,
  input  logic [VBW-1:0] vsd,
  input  logic [VBW-1:0] vsw,
  input  logic [CW-1:0]  ctrl_min,
  input  logic           hpol,
  input  logic           vpol,
  input  logic           depol,
  output logic           hsync,
  output logic           vsync,
  output logic           de,
  output logic           ctrl
);
  localparam int HX = HW + 2;
  localparam int VX = VW + 2;

  logic [HX-1:0] hs_beg, hs_end, pix_x;
  logic [VX-1:0] vs_beg, vs_end, line_x;
  logic [HW:0]   remain;
  logic          de_raw, hs_raw, vs_raw;

  assign pix_x  = {2'b00, pix};
  assign line_x = {2'b00, line};
  assign hs_beg = {2'b00, hact} + {2'b00, hsd};
  assign hs_end = hs_beg + {2'b00, hsw};
  assign vs_beg = {2'b00, vact} + {{(VX-VBW){1'b0}}, vsd};
  assign vs_end = vs_beg + {{(VX-VBW){1'b0}}, vsw};

  assign de_raw = (pix < hact) && (line < vact);
  assign hs_raw = (pix_x >= hs_beg) && (pix_x < hs_end);
  assign vs_raw = (line_x >= vs_beg) && (line_x < vs_end);
  assign remain = htot - {1'b0, pix};

  assign de    = depol ? de_raw : !de_raw;
  assign hsync = hpol  ? hs_raw : !hs_raw;
  assign vsync = vpol  ? vs_raw : !vs_raw;
  assign ctrl  = !de_raw && (remain >= {{(HW+1-CW){1'b0}}, ctrl_min});
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
  import vtg_pkg::*;
#(
  parameter int          DEF_HACT = 16,
  parameter int          DEF_HBLK = 8,
  parameter int          DEF_VACT = 4,
  parameter int          DEF_VBLK = 3,
  parameter int          DEF_HSD  = 2,
  parameter int          DEF_HSW  = 3,
  parameter int          DEF_VSD  = 1,
  parameter int          DEF_VSW  = 1,
  parameter int          DEF_CMIN = 12,
  parameter logic [7:0]  DEF_CFG  = 8'h70
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          ctrl_period,
  output logic [15:0]   pix_cnt,
  output logic [15:0]   line_cnt,
  output logic          dvi_mode,
  output logic          interlaced
);
  localparam timing_t RST = '{
    vpol:     DEF_CFG[6],
    hpol:     DEF_CFG[5],
    depol:    DEF_CFG[4],
    dvi:      DEF_CFG[3],
    intl:     DEF_CFG[0],
    ctrl_min: CW'(DEF_CMIN),
    vsw:      VBW'(DEF_VSW),
    vsd:      VBW'(DEF_VSD),
    vblk:     VBW'(DEF_VBLK),
    vact:     VW'(DEF_VACT),
    hsw:      HW'(DEF_HSW),
    hsd:      HW'(DEF_HSD),
    hblk:     HW'(DEF_HBLK),
    hact:     HW'(DEF_HACT)
  };

  timing_t     act;
  logic        frame_end;
  logic [HW:0] htot;
  logic [VW:0] vtot;

  assign htot = {1'b0, act.hact} + {1'b0, act.hblk};
  assign vtot = {1'b0, act.vact} + {{(VW+1-VBW){1'b0}}, act.vblk};

  vtg_regs #(.RST(RST)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .load  (frame_end),
    .act   (act)
  );

  vtg_counters u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .htot      (htot),
    .vtot      (vtot),
    .pix       (pix_cnt),
    .line      (line_cnt),
    .frame_end (frame_end)
  );

  vtg_decode u_dec (
    .pix      (pix_cnt),
    .line     (line_cnt),
    .htot     (htot),
    .hact     (act.hact),
    .hsd      (act.hsd),
    .hsw      (act.hsw),
    .vact     (act.vact),
    .vsd      (act.vsd),
    .vsw      (act.vsw),
    .ctrl_min (act.ctrl_min),
    .hpol     (act.hpol),
    .vpol     (act.vpol),
    .depol    (act.depol),
    .hsync    (hsync),
    .vsync    (vsync),
    .de       (de),
    .ctrl     (ctrl_period)
  );

  assign dvi_mode   = act.dvi;
  assign interlaced = act.intl;
endmodule

// File: rtl/vtg_chk.sv
module vtg_chk
  import vtg_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [HW-1:0] pix,
  input logic [VW-1:0] line,
  input logic          de,
  input logic          ctrl,
  input timing_t       act
);
  // R1
  pix_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix != 0) |-> (pix == HW'($past(pix) + 1'b1)));

  // R1
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line) |-> (pix == 0));

  // R9
  frame_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((pix == 0) && (line == 0)) |-> $stable(act));

  // R7
  ctrl_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl |-> (de == !act.depol));

  // R3
  de_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (de == act.depol) |-> (line < act.vact));
endmodule

bind vid_timing_gen vtg_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .pix   (pix_cnt),
  .line  (line_cnt),
  .de    (de),
  .ctrl  (ctrl_period),
  .act   (act)
);

// File: tb/test_vid_timing_gen.sv
`timescale 1ns/1ps
module test_vid_timing_gen;
  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic        hsync, vsync, de, ctrl_period, dvi_mode, interlaced;
  logic [15:0] pix_cnt, line_cnt;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  vid_timing_gen i_vid_timing_gen (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .hsync(hsync), .vsync(vsync), .de(de),
    .ctrl_period(ctrl_period), .pix_cnt(pix_cnt), .line_cnt(line_cnt),
    .dvi_mode(dvi_mode), .interlaced(interlaced)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // Behavioural model: byte images of the staging and working registers
  int m_stg [16];
  int m_act [16];
  int m_pix, m_line;

  function automatic int defv(int a);
    case (a)
      0: return 'h70; 1: return 16; 3: return 8; 5: return 4; 7: return 3;
      8: return 2; 10: return 3; 12: return 1; 13: return 1; 14: return 12;
      default: return 0;
    endcase
  endfunction

  function automatic int f16(int lo, int hi); return m_act[hi]*256 + m_act[lo]; endfunction
  function automatic int htot_m(); return f16(1,2) + f16(3,4); endfunction
  function automatic int vtot_m(); return f16(5,6) + m_act[7]; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin m_stg[i] = defv(i); m_act[i] = defv(i); end
      m_pix = 0; m_line = 0;
    end else begin
      int ht, vt;
      ht = htot_m(); vt = vtot_m();
      if (m_pix + 1 >= ht) begin
        m_pix = 0;
        if (m_line + 1 >= vt) begin
          m_line = 0;
          for (int i = 0; i < 16; i++) m_act[i] = m_stg[i];
        end else m_line = m_line + 1;
      end else m_pix = m_pix + 1;
      if (reg_we && reg_addr != 4'd15) m_stg[reg_addr] = reg_wdata;
    end
  end

  task automatic chk(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (pix %0d line %0d)", tag, got, exp, m_pix, m_line);
    end
  endtask

  function automatic int pol(int raw, int bitv); return bitv ? raw : (raw ? 0 : 1); endfunction

  always @(negedge clk) begin
    if (!done) begin
      int ha, hd, hw, va, vd, vw, cfg, der, hsr, vsr, ce;
      ha = f16(1,2); hd = f16(8,9); hw = f16(10,11);
      va = f16(5,6); vd = m_act[12]; vw = m_act[13]; cfg = m_act[0];
      der = (m_pix < ha && m_line < va) ? 1 : 0;
      hsr = (m_pix >= ha + hd && m_pix < ha + hd + hw) ? 1 : 0;
      vsr = (m_line >= va + vd && m_line < va + vd + vw) ? 1 : 0;
      ce  = (!der && (htot_m() - m_pix) >= m_act[14]) ? 1 : 0;
      chk("R1,R2 pix_cnt", pix_cnt, m_pix);
      chk("R1 line_cnt", line_cnt, m_line);
      chk("R3,R6 de", de, pol(der, (cfg >> 4) & 1));
      chk("R4,R6 hsync", hsync, pol(hsr, (cfg >> 5) & 1));
      chk("R5,R6 vsync", vsync, pol(vsr, (cfg >> 6) & 1));
      chk("R7 ctrl_period", ctrl_period, ce);
      chk("R8 dvi_mode", dvi_mode, (cfg >> 3) & 1);
      chk("R8 interlaced", interlaced, cfg & 1);
    end
  end

  task automatic wr_now(int a, int d);
    reg_we = 1; reg_addr = 4'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_now(a, d);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    // R10: reset state at the ports
    chk("R10 reset pix", pix_cnt, 0);
    chk("R10 reset line", line_cnt, 0);
    chk("R10 reset de", de, 1);
    chk("R10 reset dvi", dvi_mode, 0);
    rst_n = 1;
    repeat (400) @(negedge clk);

    // R2 R9: new timing written mid-frame, high bytes exercised
    wr(0, 'h09);
    wr(1, 20);  wr(2, 0);
    wr(3, 5);   wr(4, 1);
    wr(5, 3);   wr(6, 0);
    wr(7, 2);
    wr(8, 0);   wr(9, 1);
    wr(10, 4);  wr(11, 0);
    wr(12, 0);  wr(13, 1);
    wr(14, 12);
    wr(15, 'hff); // R2: ignored address
    repeat (3000) @(negedge clk);

    // R9: write lands on the same edge as the frame wrap
    do @(negedge clk); while (!(m_pix == htot_m() - 1 && m_line == vtot_m() - 1));
    wr_now(1, 10);
    do @(negedge clk); while (!(m_line == 0 && m_pix == 15));
    chk("R9 held-back write", de, 0);
    do @(negedge clk); while (!(m_line == 1 && m_pix == 15));
    do @(negedge clk); while (!(m_line == 0 && m_pix == 15));
    chk("R9 write applied next frame", de, 1);

    // R7: zero and oversized minimum control durations
    wr(14, 0);
    repeat (3000) @(negedge clk);
    wr(14, 255);
    repeat (3000) @(negedge clk);

    // back to a short raster, active-high strobes
    wr(0, 'h70); wr(3, 8); wr(4, 0); wr(8, 2); wr(9, 0); wr(14, 5);
    repeat (2000) @(negedge clk);
    finish_run();
  end
endmodule